// File: doc/BRIEF.md
# Sequence-unlocked drive timing configuration bank

This block sits on the device side of a legacy parallel disk-interface channel and hides its timing configuration behind the ordinary task-file I/O window. The host reaches small offsets of the command block with byte and 16-bit accesses. Normally those accesses are plain task-file traffic: reads return the task-file value supplied on an input, and writes leave the configuration alone.

A detector watches for a fixed access pattern: two consecutive 16-bit reads of offset 1, then a byte write of 3 to offset 2. Once it sees the pattern, the block opens. While it is open, byte writes to the window land in a small register bank. A select value written to the miscellaneous index picks which drive's read and write timing bytes receive the next timing writes. The same index also carries the address-setup field that both drives share. A magic value written to the control index raises a flag that overrides the strapped default timings. A byte write of 0x83 to offset 2 closes the bank again.

Separately from the lock state, the host can probe a clock-speed strap pin. It writes 0xFF to offset 5 and then does a 16-bit read of offset 5.

Top module: `cfgtrap_top`

## Requirements
- R1: The block opens (`cfg_unlocked` = 1 one cycle after the write) only after two consecutive 16-bit reads of offset 1 followed by a byte write of 0x03 to offset 2; further 16-bit reads of offset 1 after the second one keep the detector armed for the write.
- R2: While locked, any access that is not the expected next step resets the detector, so the following 0x03 write does not open the block: a single 16-bit read of offset 1, a byte read of offset 1, a different offset or a value other than 0x03. Cycles with `bus_valid` = 0 do not count as accesses.
- R3: While open, a byte write of 0x83 to offset 2 locks the block one cycle later; writes after that have no effect on the configuration outputs.
- R4: While locked, no write changes `read_timing`, `write_timing`, `addr_setup` or `strap_override`.
- R5: While open, a byte write to offset 0 stores the full byte as the read timing of the selected drive, and one to offset 1 stores it as that drive's write timing. Drive d occupies bits [8d+7:8d] of each timing output, and the new value is visible one cycle after the write. 16-bit writes store nothing.
- R6: While open, a byte write to offset 6 whose upper nibble is zero selects drive number = low nibble (values at or above the drive count are ignored). A value with a nonzero upper nibble sets the shared `addr_setup` to bits [5:4] and leaves the select unchanged (0x10, 0x20, 0x30 give 1, 2, 3).
- R7: While open, a byte write of 0x85 to offset 3 sets `strap_override`; any other value written to offset 3 clears it.
- R8: In either lock state, a byte write of 0xFF to offset 5 arms a probe. If the next access is a 16-bit read of offset 5, it returns `clk_strap` in bit 0 with all other bits zero. Any access disarms the probe.
- R9: Every other read returns `tf_rdata` as sampled with the read. `rd_data` is updated one cycle after a read access and holds its value otherwise.
- R10: After reset the block is locked, both drives' timing bytes are 0x6B, the select is drive 0, `addr_setup` is 3, `strap_override` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 3 | Offset within the command block |
| bus_wdata | input | 8 | Byte write data |
| tf_rdata | input | 16 | Task-file read value from the normal register path |
| clk_strap | input | 1 | Clock-speed strap pin |
| rd_data | output | 16 | Read data, registered |
| cfg_unlocked | output | 1 | Configuration bank open |
| read_timing | output | 16 | Read-cycle timing byte per drive |
| write_timing | output | 16 | Write-cycle timing byte per drive |
| addr_setup | output | 2 | Shared address-setup field |
| strap_override | output | 1 | Override strapped default timings |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it: the lock state, each stored timing byte, the select and setup fields, the override flag and the read data. The bench applies each access just after a rising edge and keeps it for one cycle. It compares the outputs at the following falling edge, by then one register stage has passed. A behavioural model is stepped on the same rising edge and compared on every falling edge. Directed checks look at the ports in the cycle after the last access of each scenario, so an ignored write is visible as unchanged outputs before the next stimulus.

// File: rtl/cfgtrap_pkg.sv
package cfgtrap_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DATA_W = 16;

    // window offsets and bank indices whose meaning the logic depends on
    localparam logic [ADDR_W-1:0] OFS_ERROR = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_GATE  = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_RDTIM = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_WRTIM = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_PROBE = 3'd5;
    localparam logic [ADDR_W-1:0] IDX_MISC  = 3'd6;

    localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h03;
    localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'h83;
    localparam logic [BYTE_W-1:0] KEY_OVR   = 8'h85;
    localparam logic [BYTE_W-1:0] KEY_PROBE = 8'hFF;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2,
        SEQ_OPEN = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_acc_t;

    typedef struct packed {
        logic       is_sel;
        logic [3:0] sel;
        logic       is_setup;
        logic [1:0] setup;
    } misc_dec_t;

    function automatic logic hit_byte_write(bus_acc_t a, logic [ADDR_W-1:0] ofs,
                                            logic [BYTE_W-1:0] val);
        return a.valid && a.write && !a.wide && (a.addr == ofs) && (a.wdata == val);
    endfunction

    function automatic logic hit_wide_read(bus_acc_t a, logic [ADDR_W-1:0] ofs);
        return a.valid && !a.write && a.wide && (a.addr == ofs);
    endfunction

    function automatic misc_dec_t decode_misc(logic [BYTE_W-1:0] val);
        misc_dec_t m;
        m.is_sel   = (val[7:4] == 4'd0);
        m.sel      = val[3:0];
        m.is_setup = (val[7:4] != 4'd0);
        m.setup    = val[5:4];
        return m;
    endfunction

endpackage

// File: rtl/cfgtrap_seq.sv
module cfgtrap_seq
    import cfgtrap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_acc_t acc,
    output logic     unlocked
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (hit_wide_read(acc, OFS_ERROR)) state_d = SEQ_ONE;
            end
            SEQ_ONE: begin
                if (acc.valid)
                    state_d = hit_wide_read(acc, OFS_ERROR) ? SEQ_TWO : SEQ_IDLE;
            end
            SEQ_TWO: begin
                if (acc.valid) begin
                    if (hit_wide_read(acc, OFS_ERROR))
                        state_d = SEQ_TWO;
                    else if (hit_byte_write(acc, OFS_GATE, KEY_OPEN))
                        state_d = SEQ_OPEN;
                    else
                        state_d = SEQ_IDLE;
                end
            end
            SEQ_OPEN: begin
                if (hit_byte_write(acc, OFS_GATE, KEY_CLOSE)) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == SEQ_OPEN);

endmodule

// File: rtl/cfgtrap_bank.sv
module cfgtrap_bank
    import cfgtrap_pkg::*;
#(
    parameter int unsigned        NUM_DRIVES   = 2,
    parameter logic [BYTE_W-1:0]  RESET_TIMING = 8'h6B,
    parameter logic [1:0]         RESET_SETUP  = 2'd3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_idx,
    input  logic [BYTE_W-1:0]            wr_val,
    output logic [NUM_DRIVES*BYTE_W-1:0] read_timing,
    output logic [NUM_DRIVES*BYTE_W-1:0] write_timing,
    output logic [1:0]                   addr_setup,
    output logic                         override
);

    localparam int unsigned SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

    logic [SEL_W-1:0] sel_q;
    logic [1:0]       setup_q;
    logic             ovr_q;
    misc_dec_t        misc;
    logic             sel_ok;

    assign misc   = decode_misc(wr_val);
    assign sel_ok = misc.is_sel && ({28'd0, misc.sel} < NUM_DRIVES);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            setup_q <= RESET_SETUP;
            ovr_q   <= 1'b0;
        end else if (wr_en) begin
            if (wr_idx == IDX_MISC) begin
                if (sel_ok)        sel_q   <= misc.sel[SEL_W-1:0];
                if (misc.is_setup) setup_q <= misc.setup;
            end
            if (wr_idx == IDX_CTRL) ovr_q <= (wr_val == KEY_OVR);
        end
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        logic [BYTE_W-1:0] rd_q;
        logic [BYTE_W-1:0] wr_q;
        logic              mine;

        assign mine = wr_en && (sel_q == SEL_W'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= RESET_TIMING;
                wr_q <= RESET_TIMING;
            end else if (mine) begin
                if (wr_idx == IDX_RDTIM) rd_q <= wr_val;
                if (wr_idx == IDX_WRTIM) wr_q <= wr_val;
            end
        end

        assign read_timing[d*BYTE_W +: BYTE_W]  = rd_q;
        assign write_timing[d*BYTE_W +: BYTE_W] = wr_q;
    end

    assign addr_setup = setup_q;
    assign override   = ovr_q;

endmodule

// File: rtl/cfgtrap_readback.sv
module cfgtrap_readback
    import cfgtrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_acc_t          acc,
    input  logic [DATA_W-1:0] tf_rdata,
    input  logic              clk_strap,
    output logic [DATA_W-1:0] rd_data
);

    logic              armed_q;
    logic [DATA_W-1:0] rd_q;
    logic              probe_hit;

    assign probe_hit = armed_q && hit_wide_read(acc, IDX_PROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            rd_q    <= '0;
        end else if (acc.valid) begin
            armed_q <= hit_byte_write(acc, IDX_PROBE, KEY_PROBE);
            if (!acc.write)
                rd_q <= probe_hit ? {{(DATA_W-1){1'b0}}, clk_strap} : tf_rdata;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cfgtrap_top.sv
module cfgtrap_top
    import cfgtrap_pkg::*;
#(
    parameter int unsigned       NUM_DRIVES   = 2,
    parameter logic [BYTE_W-1:0] RESET_TIMING = 8'h6B,
    parameter logic [1:0]        RESET_SETUP  = 2'd3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic                         bus_wide,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [BYTE_W-1:0]            bus_wdata,
    input  logic [DATA_W-1:0]            tf_rdata,
    input  logic                         clk_strap,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         cfg_unlocked,
    output logic [NUM_DRIVES*BYTE_W-1:0] read_timing,
    output logic [NUM_DRIVES*BYTE_W-1:0] write_timing,
    output logic [1:0]                   addr_setup,
    output logic                         strap_override
);

    bus_acc_t acc;
    logic     bank_we;

    assign acc.valid = bus_valid;
    assign acc.write = bus_write;
    assign acc.wide  = bus_wide;
    assign acc.addr  = bus_addr;
    assign acc.wdata = bus_wdata;

    cfgtrap_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .unlocked (cfg_unlocked)
    );

    assign bank_we = cfg_unlocked && bus_valid && bus_write && !bus_wide;

    cfgtrap_bank #(
        .NUM_DRIVES   (NUM_DRIVES),
        .RESET_TIMING (RESET_TIMING),
        .RESET_SETUP  (RESET_SETUP)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (bank_we),
        .wr_idx       (bus_addr),
        .wr_val       (bus_wdata),
        .read_timing  (read_timing),
        .write_timing (write_timing),
        .addr_setup   (addr_setup),
        .override     (strap_override)
    );

    cfgtrap_readback u_rb (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .tf_rdata  (tf_rdata),
        .clk_strap (clk_strap),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/cfgtrap_checker.sv
module cfgtrap_checker #(
    parameter int unsigned NUM_DRIVES = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic                    bus_wide,
    input logic [2:0]              bus_addr,
    input logic [7:0]              bus_wdata,
    input logic                    clk_strap,
    input logic [15:0]             rd_data,
    input logic                    cfg_unlocked,
    input logic [NUM_DRIVES*8-1:0] read_timing,
    input logic [NUM_DRIVES*8-1:0] write_timing,
    input logic [1:0]              addr_setup,
    input logic                    strap_override
);

    logic key_wr, close_wr, ctrl_wr, probe_wr, probe_rd;
    assign key_wr   = bus_valid && bus_write && !bus_wide && bus_addr == 3'd2 && bus_wdata == 8'h03;
    assign close_wr = bus_valid && bus_write && !bus_wide && bus_addr == 3'd2 && bus_wdata == 8'h83;
    assign ctrl_wr  = bus_valid && bus_write && !bus_wide && bus_addr == 3'd3;
    assign probe_wr = bus_valid && bus_write && !bus_wide && bus_addr == 3'd5 && bus_wdata == 8'hFF;
    assign probe_rd = bus_valid && !bus_write && bus_wide && bus_addr == 3'd5;

    // R1: opening is always caused by the key write
    a_r1_open_needs_key: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_unlocked) |-> $past(key_wr));

    // R2: while locked, any non-key access keeps the block locked
    a_r2_no_stray_open: assert property (@(posedge clk) disable iff (rst)
        (!cfg_unlocked && bus_valid && !key_wr) |=> !cfg_unlocked);

    // R3: relock write closes the bank
    a_r3_close: assert property (@(posedge clk) disable iff (rst)
        (cfg_unlocked && close_wr) |=> !cfg_unlocked);

    // R4: locked state freezes configuration outputs
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_unlocked |=> ($stable(read_timing) && $stable(write_timing)
                           && $stable(addr_setup) && $stable(strap_override)));

    // R7: override follows the value written to the control index
    a_r7_override: assert property (@(posedge clk) disable iff (rst)
        (cfg_unlocked && ctrl_wr) |=> (strap_override == ($past(bus_wdata) == 8'h85)));

    // R8: armed probe read returns the strap pin
    a_r8_probe: assert property (@(posedge clk) disable iff (rst)
        (probe_rd && $past(probe_wr) && !$past(rst)) |=> (rd_data == {15'd0, $past(clk_strap)}));

    // R9: read data only moves on a read
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> $stable(rd_data));

endmodule

bind cfgtrap_top cfgtrap_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_wide       (bus_wide),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .clk_strap      (clk_strap),
    .rd_data        (rd_data),
    .cfg_unlocked   (cfg_unlocked),
    .read_timing    (read_timing),
    .write_timing   (write_timing),
    .addr_setup     (addr_setup),
    .strap_override (strap_override)
);

// File: tb/tb_cfgtrap_top.sv
`timescale 1ns/1ps
module tb_cfgtrap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] tf_rdata = 16'h1234;
    logic        clk_strap = 1'b0;
    logic [15:0] rd_data, read_timing, write_timing;
    logic        cfg_unlocked, strap_override;
    logic [1:0]  addr_setup;

    always #4 clk = ~clk;   // 125 MHz

    cfgtrap_top dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .tf_rdata(tf_rdata), .clk_strap(clk_strap), .rd_data(rd_data),
        .cfg_unlocked(cfg_unlocked), .read_timing(read_timing),
        .write_timing(write_timing), .addr_setup(addr_setup),
        .strap_override(strap_override)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    int          m_seq;      // reads of offset 1 seen in a row (capped at 2)
    bit          m_unl, m_armed, m_ovr;
    int          m_sel;
    logic [1:0]  m_setup;
    logic [7:0]  m_rt [2];
    logic [7:0]  m_wt [2];
    logic [15:0] m_rd;

    always @(posedge clk) begin
        bit bw, wr;
        if (rst) begin
            m_seq = 0; m_unl = 0; m_armed = 0; m_ovr = 0; m_sel = 0;
            m_setup = 2'd3; m_rd = 16'h0;
            m_rt[0] = 8'h6B; m_rt[1] = 8'h6B; m_wt[0] = 8'h6B; m_wt[1] = 8'h6B;
        end else if (bus_valid) begin
            bw = bus_write && !bus_wide;
            wr = !bus_write && bus_wide;
            if (!bus_write)
                m_rd = (wr && bus_addr == 5 && m_armed) ? {15'd0, clk_strap} : tf_rdata;
            m_armed = bw && bus_addr == 5 && bus_wdata == 8'hFF;
            if (m_unl) begin
                if (bw) begin
                    case (bus_addr)
                        3'd0: m_rt[m_sel] = bus_wdata;
                        3'd1: m_wt[m_sel] = bus_wdata;
                        3'd2: if (bus_wdata == 8'h83) m_unl = 0;
                        3'd3: m_ovr = (bus_wdata == 8'h85);
                        3'd6: begin
                            if (bus_wdata[7:4] == 0) begin
                                if (bus_wdata[3:0] < 2) m_sel = bus_wdata[3:0];
                            end else m_setup = bus_wdata[5:4];
                        end
                        default: ;
                    endcase
                end
            end else begin
                if (wr && bus_addr == 1) m_seq = (m_seq == 0) ? 1 : 2;
                else if (m_seq == 2 && bw && bus_addr == 2 && bus_wdata == 8'h03) begin
                    m_unl = 1; m_seq = 0;
                end else m_seq = 0;
            end
        end
    end

    task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            cmp("R1", "model cfg_unlocked", {15'd0, cfg_unlocked}, {15'd0, m_unl});
            cmp("R5", "model read_timing", read_timing, {m_rt[1], m_rt[0]});
            cmp("R5", "model write_timing", write_timing, {m_wt[1], m_wt[0]});
            cmp("R6", "model addr_setup", {14'd0, addr_setup}, {14'd0, m_setup});
            cmp("R7", "model strap_override", {15'd0, strap_override}, {15'd0, m_ovr});
            cmp("R9", "model rd_data", rd_data, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(bit w, bit wide, logic [2:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = w; bus_wide = wide; bus_addr = a; bus_wdata = d;
    endtask

    task automatic settle();
        @(posedge clk); #1;
        bus_valid = 0;
        @(negedge clk);
    endtask

    task automatic bwr(logic [2:0] a, logic [7:0] d); acc(1, 0, a, d); endtask
    task automatic wrd(logic [2:0] a); acc(0, 1, a, 8'h00); endtask

    task automatic report();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10 reset state
        cmp("R10", "reset unlocked", {15'd0, cfg_unlocked}, 16'd0);
        cmp("R10", "reset read_timing", read_timing, 16'h6B6B);
        cmp("R10", "reset write_timing", write_timing, 16'h6B6B);
        cmp("R10", "reset addr_setup", {14'd0, addr_setup}, 16'd3);
        cmp("R10", "reset override", {15'd0, strap_override}, 16'd0);
        cmp("R10", "reset rd_data", rd_data, 16'd0);

        // R2: only one read of offset 1
        wrd(1); bwr(2, 8'h03); settle();
        cmp("R2", "single read stays locked", {15'd0, cfg_unlocked}, 16'd0);
        // R2: byte read breaks the run
        wrd(1); acc(0, 0, 1, 0); wrd(1); bwr(2, 8'h03); settle();
        cmp("R2", "byte read resets", {15'd0, cfg_unlocked}, 16'd0);
        // R2: wrong key value
        wrd(1); wrd(1); bwr(2, 8'h04); settle();
        cmp("R2", "wrong key stays locked", {15'd0, cfg_unlocked}, 16'd0);
        // R2: other offset in between
        wrd(1); wrd(1); wrd(3); bwr(2, 8'h03); settle();
        cmp("R2", "other offset resets", {15'd0, cfg_unlocked}, 16'd0);

        // R4: locked writes ignored
        bwr(6, 8'h01); bwr(0, 8'h11); bwr(1, 8'h22); bwr(6, 8'h10); bwr(3, 8'h85); settle();
        cmp("R4", "locked read_timing", read_timing, 16'h6B6B);
        cmp("R4", "locked write_timing", write_timing, 16'h6B6B);
        cmp("R4", "locked addr_setup", {14'd0, addr_setup}, 16'd3);
        cmp("R4", "locked override", {15'd0, strap_override}, 16'd0);

        // R1: proper unlock, idle gap between reads allowed
        wrd(1); settle(); wrd(1); bwr(2, 8'h03); settle();
        cmp("R1", "unlocked after key", {15'd0, cfg_unlocked}, 16'd1);

        // R5 R6: banked writes
        bwr(6, 8'h01); bwr(0, 8'h56); bwr(1, 8'h42); settle();
        cmp("R5", "drive1 read slot", read_timing, 16'h566B);
        cmp("R5", "drive1 write slot", write_timing, 16'h426B);
        bwr(6, 8'h00); bwr(0, 8'h58); settle();
        cmp("R6", "select drive0", read_timing, 16'h5658);
        bwr(6, 8'h20); bwr(1, 8'h32); settle();
        cmp("R6", "setup field", {14'd0, addr_setup}, 16'd2);
        cmp("R6", "setup keeps select", write_timing, 16'h4232);
        bwr(6, 8'h07); bwr(0, 8'h21); settle();
        cmp("R6", "out-of-range select ignored", read_timing, 16'h5621);
        acc(1, 1, 0, 8'h99); settle();
        cmp("R5", "wide write ignored", read_timing, 16'h5621);

        // R7 override flag
        bwr(3, 8'h85); settle();
        cmp("R7", "override set", {15'd0, strap_override}, 16'd1);
        bwr(3, 8'h84); settle();
        cmp("R7", "override cleared", {15'd0, strap_override}, 16'd0);
        bwr(3, 8'h85); settle();

        // R3 relock
        bwr(2, 8'h83); settle();
        cmp("R3", "relocked", {15'd0, cfg_unlocked}, 16'd0);
        bwr(0, 8'h99); bwr(3, 8'h00); settle();
        cmp("R3", "writes after relock", read_timing, 16'h5621);
        cmp("R3", "override after relock", {15'd0, strap_override}, 16'd1);

        // R8 strap probe
        clk_strap = 1; bwr(5, 8'hFF); wrd(5); settle();
        cmp("R8", "probe strap=1", rd_data, 16'h0001);
        clk_strap = 0; tf_rdata = 16'hFFFE; bwr(5, 8'hFF); wrd(5); settle();
        cmp("R8", "probe strap=0", rd_data, 16'h0000);
        tf_rdata = 16'hA5C3; bwr(5, 8'hFF); acc(0, 0, 5, 0); settle();
        cmp("R8", "byte read not probe", rd_data, 16'hA5C3);
        clk_strap = 1; tf_rdata = 16'h0F0E; wrd(5); settle();
        cmp("R8", "unarmed read", rd_data, 16'h0F0E);

        // R9 plain reads and hold
        tf_rdata = 16'hBEEF; wrd(1); settle();
        cmp("R9", "task-file read", rd_data, 16'hBEEF);
        tf_rdata = 16'h0000; bwr(4, 8'h12); settle();
        cmp("R9", "hold after write", rd_data, 16'hBEEF);

        // R1: three reads then key still opens
        wrd(1); wrd(1); wrd(1); bwr(2, 8'h03); settle();
        cmp("R1", "three reads then key", {15'd0, cfg_unlocked}, 16'd1);
        bwr(2, 8'h55); settle();
        cmp("R3", "other gate value keeps open", {15'd0, cfg_unlocked}, 16'd1);

        repeat (2) @(negedge clk);
        report();
    end

endmodule